// File: doc/BRIEF.md
# Software trap entry sequencer

This block carries out the hardware part of entering a software trap handler for a small 16-bit processor whose program counter is 24 bits wide. When the core executes a trap instruction it presents a request with a 2-bit vector number, the return address, the current condition code byte, a user-enable control bit and the stack pointer. The sequencer saves the condition codes and return address as a packed 4-byte frame just below the stack pointer. It sets the interrupt mask bits and reads the handler address from a vector table. It then returns the new program counter, stack pointer and condition code byte to the core.

The memory side is a single word-wide port with a request/ready handshake. The memory is big-endian: a 16-bit word at an even address A holds byte A in bits 15:8 and byte A+1 in bits 7:0. Only even-aligned word accesses are issued. The core is expected to hold off its own memory traffic while `busy_o` is high.

Top module: `trap_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy_o, done_o, err_o and mem_req_o are all low.
- R2: A request is accepted when req_i is high at a clock edge while the sequencer is idle. busy_o is high from the next cycle until the cycle of done_o or err_o, inclusive. req_i and the request fields are ignored while busy_o is high.
- R3: The first access is a write (mem_we_o high) to old SP-4 with data {CCR, PC[23:16]}. This stores the unmodified CCR at byte SP-4 and PC[23:16] at SP-3.
- R4: The second access is a write to old SP-2 with data PC[15:0]. This stores PC[15:8] at SP-2 and PC[7:0] at SP-1.
- R5: Every write goes to an even address. mem_we_o is high for the two frame writes and low for the vector reads.
- R6: The third and fourth accesses are reads (mem_we_o low). They go to VEC_BASE + 4*(8 + vector) and to that address + 2.
- R7: new_pc_o is {bits 7:0 of the first read word, the second read word}.
- R8: new_sp_o equals the old stack pointer minus 4, modulo 2^ADDR_W.
- R9: new_ccr_o is the saved CCR with bit 7 (interrupt mask) set. When the user-enable bit is 0, bit 6 (user mask) is also set. All other bits are kept.
- R10: Each access keeps mem_req_o, mem_addr_o, mem_we_o and mem_wdata_o steady until a clock edge where mem_rdy_i is high. The access completes at that edge.
- R11: A request with an odd stack pointer raises err_o for exactly one cycle, one cycle after acceptance. No memory access and no done_o follow, and the sequencer returns to idle.
- R12: done_o is a one-cycle pulse in the cycle after the edge that completes the last read. new_pc_o, new_sp_o and new_ccr_o are valid then and hold until the next completed sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Trap request |
| vec_i | input | 2 | Trap vector number |
| ret_pc_i | input | 24 | Return address to save |
| ccr_i | input | 8 | Condition code byte before entry |
| user_en_i | input | 1 | User-enable control bit |
| sp_i | input | ADDR_W | Stack pointer before entry |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed (one-cycle pulse) |
| err_o | output | 1 | Misaligned stack pointer (one-cycle pulse) |
| new_pc_o | output | 24 | Handler start address |
| new_sp_o | output | ADDR_W | Stack pointer after the push |
| new_ccr_o | output | 8 | Condition code byte with masks set |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Byte address, always even |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, sampled at the completing edge |
| mem_rdy_i | input | 1 | Access completes at this edge |

## Verification
The assertions assume that the memory returns read data in the same cycle that mem_rdy_i is high. They also assume that mem_rdy_i is meaningful only while mem_req_o is high. The bench's memory model answers reads combinationally from the address, which satisfies the first assumption. It raises ready either always or at random, which tests the stall behaviour. Request fields change only after a clock edge, so the sampling edge never sees a moving request. Noise on req_i during a sequence is limited to the first two busy cycles, which keeps a stray request from landing on the idle cycle after done.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned PC_W       = 24;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned CCR_W      = 8;
  localparam int unsigned VEC_W      = 2;
  localparam int unsigned CCR_I_BIT  = 7;
  localparam int unsigned CCR_UI_BIT = 6;
  localparam int unsigned VEC_OFS    = 8;
  localparam int unsigned ENTRY_B    = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_VEC_HI,
    ST_VEC_LO,
    ST_DONE,
    ST_ERR
  } trap_state_e;
endpackage

// File: rtl/trap_mask_upd.sv
module trap_mask_upd
  import trap_pkg::*;
(
  input  logic [CCR_W-1:0] ccr_i,
  input  logic             user_en_i,
  output logic [CCR_W-1:0] ccr_o
);
  always_comb begin
    ccr_o = ccr_i;
    ccr_o[CCR_I_BIT] = 1'b1;
    if (!user_en_i) ccr_o[CCR_UI_BIT] = 1'b1;
  end
endmodule

// File: rtl/trap_frame_gen.sv
module trap_frame_gen
  import trap_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [CCR_W-1:0]  ccr_i,
  input  logic              slot_i,   // 0: upper frame word, 1: lower
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] data_o
);
  localparam int unsigned FRAME_B = (CCR_W + PC_W) / 8;
  localparam int unsigned WORD_B  = WORD_W / 8;

  always_comb begin
    if (slot_i) begin
      addr_o = sp_i - ADDR_W'(FRAME_B - WORD_B);
      data_o = pc_i[WORD_W-1:0];
    end else begin
      addr_o = sp_i - ADDR_W'(FRAME_B);
      data_o = {ccr_i, pc_i[PC_W-1:WORD_W]};
    end
  end
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen
  import trap_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              half_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned WORD_B = WORD_W / 8;
  logic [ADDR_W-1:0] entry;

  assign entry  = VEC_BASE + ADDR_W'((VEC_OFS + 32'(vec_i)) * ENTRY_B);
  assign addr_o = half_i ? entry + ADDR_W'(WORD_B) : entry;
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        vec_i,
  input  logic [23:0]       ret_pc_i,
  input  logic [7:0]        ccr_i,
  input  logic              user_en_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [23:0]       new_pc_o,
  output logic [ADDR_W-1:0] new_sp_o,
  output logic [7:0]        new_ccr_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i,
  input  logic              mem_rdy_i
);
  localparam int unsigned HI_W    = PC_W - WORD_W;
  localparam int unsigned FRAME_B = (CCR_W + PC_W) / 8;

  trap_state_e       state_q, state_d;
  logic [ADDR_W-1:0] sp_q;
  logic [PC_W-1:0]   pc_q;
  logic [CCR_W-1:0]  ccr_q;
  logic              ue_q;
  logic [VEC_W-1:0]  vec_q;
  logic [HI_W-1:0]   vhi_q;
  logic [PC_W-1:0]   new_pc_q;
  logic [ADDR_W-1:0] new_sp_q;
  logic [CCR_W-1:0]  new_ccr_q;

  logic              accept, hs;
  logic [ADDR_W-1:0] frame_addr, vec_addr;
  logic [WORD_W-1:0] frame_data;
  logic [CCR_W-1:0]  masked_ccr;
  logic              unused_rdata_hi;

  assign unused_rdata_hi = ^mem_rdata_i[WORD_W-1:HI_W];

  assign accept = (state_q == ST_IDLE) && req_i;
  assign hs     = mem_req_o && mem_rdy_i;

  trap_frame_gen #(.ADDR_W(ADDR_W)) i_frame (
    .sp_i   (sp_q),
    .pc_i   (pc_q),
    .ccr_i  (ccr_q),
    .slot_i (state_q == ST_PUSH_LO),
    .addr_o (frame_addr),
    .data_o (frame_data)
  );

  trap_vec_gen #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) i_vec (
    .vec_i  (vec_q),
    .half_i (state_q == ST_VEC_LO),
    .addr_o (vec_addr)
  );

  trap_mask_upd i_mask (
    .ccr_i     (ccr_q),
    .user_en_i (ue_q),
    .ccr_o     (masked_ccr)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_i) state_d = sp_i[0] ? ST_ERR : ST_PUSH_HI;
      ST_PUSH_HI: if (hs) state_d = ST_PUSH_LO;
      ST_PUSH_LO: if (hs) state_d = ST_VEC_HI;
      ST_VEC_HI:  if (hs) state_d = ST_VEC_LO;
      ST_VEC_LO:  if (hs) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      ST_ERR:     state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sp_q      <= '0;
      pc_q      <= '0;
      ccr_q     <= '0;
      ue_q      <= 1'b0;
      vec_q     <= '0;
      vhi_q     <= '0;
      new_pc_q  <= '0;
      new_sp_q  <= '0;
      new_ccr_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        sp_q  <= sp_i;
        pc_q  <= ret_pc_i;
        ccr_q <= ccr_i;
        ue_q  <= user_en_i;
        vec_q <= vec_i;
      end
      if (hs && state_q == ST_VEC_HI) vhi_q <= mem_rdata_i[HI_W-1:0];
      if (hs && state_q == ST_VEC_LO) begin
        new_pc_q  <= {vhi_q, mem_rdata_i};
        new_sp_q  <= sp_q - ADDR_W'(FRAME_B);
        new_ccr_q <= masked_ccr;
      end
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = (state_q == ST_ERR);
  assign mem_we_o    = (state_q == ST_PUSH_HI) || (state_q == ST_PUSH_LO);
  assign mem_req_o   = mem_we_o || (state_q == ST_VEC_HI) || (state_q == ST_VEC_LO);
  assign mem_addr_o  = mem_we_o ? frame_addr : vec_addr;
  assign mem_wdata_o = mem_we_o ? frame_data : '0;
  assign new_pc_o    = new_pc_q;
  assign new_sp_o    = new_sp_q;
  assign new_ccr_o   = new_ccr_q;

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R5
  even_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> !mem_addr_o[0]);

  // R11
  odd_sp_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i && sp_i[0]) |=> (err_o && !mem_req_o));

  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  // R2
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !err_o) |=> busy_o);

  // R9
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (new_ccr_o[CCR_I_BIT] && (ue_q || new_ccr_o[CCR_UI_BIT])));
endmodule

// File: tb/test_trap_seq.sv
`timescale 1ns/1ps
module test_trap_seq;
  localparam int unsigned AW = 24;
  localparam logic [AW-1:0] BASE = 24'h000100;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic [1:0]    vec_i = '0;
  logic [23:0]   ret_pc_i = '0;
  logic [7:0]    ccr_i = '0;
  logic          user_en_i = 1'b0;
  logic [AW-1:0] sp_i = '0;
  logic          busy_o, done_o, err_o, mem_req_o, mem_we_o;
  logic [23:0]   new_pc_o;
  logic [AW-1:0] new_sp_o, mem_addr_o;
  logic [7:0]    new_ccr_o;
  logic [15:0]   mem_wdata_o, mem_rdata_i;
  logic          mem_rdy_i = 1'b1;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit rdy_rand = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] mem_fn(logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3} + 16'(a[AW-1:16]);
  endfunction

  assign mem_rdata_i = mem_fn(mem_addr_o);

  trap_seq #(.ADDR_W(AW), .VEC_BASE(BASE)) i_trap_seq (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .vec_i(vec_i),
    .ret_pc_i(ret_pc_i), .ccr_i(ccr_i), .user_en_i(user_en_i), .sp_i(sp_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .new_pc_o(new_pc_o),
    .new_sp_o(new_sp_o), .new_ccr_o(new_ccr_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int          m_ph = 0;      // 0 idle, 1..4 accesses, 5 done, 6 err
  logic [AW-1:0] m_sp;
  logic [23:0] m_pc;
  logic [7:0]  m_ccr;
  logic        m_ue;
  logic [1:0]  m_vec;
  logic [15:0] m_hi;
  logic [23:0] e_pc;
  logic [AW-1:0] e_sp;
  logic [7:0]  e_ccr;
  bit          m_have = 1'b0;

  always @(negedge clk) begin
    logic [AW-1:0] ea;
    if (!rst_ni) begin
      // R1
      chk(!busy_o && !done_o && !err_o && !mem_req_o, "R1 reset outputs",
          {busy_o, done_o, err_o, mem_req_o}, 0);
      m_ph = 0;
      m_have = 1'b0;
    end else begin
      // R2 busy window, R11 err pulse, R12 done pulse
      chk(busy_o == (m_ph != 0), "R2 busy", busy_o, m_ph != 0);
      chk(done_o == (m_ph == 5), "R12 done", done_o, m_ph == 5);
      chk(err_o == (m_ph == 6), "R11 err", err_o, m_ph == 6);
      chk(mem_req_o == (m_ph >= 1 && m_ph <= 4), "R10 mem_req", mem_req_o,
          m_ph >= 1 && m_ph <= 4);
      if (m_ph >= 1 && m_ph <= 4) begin
        case (m_ph)
          1: ea = m_sp - 24'd4;
          2: ea = m_sp - 24'd2;
          3: ea = BASE + AW'(4 * (8 + int'(m_vec)));
          default: ea = BASE + AW'(4 * (8 + int'(m_vec))) + 24'd2;
        endcase
        chk(mem_addr_o == ea, m_ph <= 2 ? "R3/R4 write addr" : "R6 read addr",
            mem_addr_o, ea);
        chk(mem_we_o == (m_ph <= 2), "R5 we", mem_we_o, m_ph <= 2);
        if (m_ph == 1)
          chk(mem_wdata_o == {m_ccr, m_pc[23:16]}, "R3 frame hi", mem_wdata_o,
              {m_ccr, m_pc[23:16]});
        if (m_ph == 2)
          chk(mem_wdata_o == m_pc[15:0], "R4 frame lo", mem_wdata_o, m_pc[15:0]);
      end
      if (m_have && (m_ph == 5 || m_ph == 0 || m_ph == 6)) begin
        chk(new_pc_o == e_pc, "R7 new_pc", new_pc_o, e_pc);
        chk(new_sp_o == e_sp, "R8 new_sp", new_sp_o, e_sp);
        chk(new_ccr_o == e_ccr, "R9 new_ccr", new_ccr_o, e_ccr);
      end
      mem_rdy_i = rdy_rand ? 1'($urandom_range(0, 1)) : 1'b1;
      // advance model to the next edge
      if (m_ph == 0) begin
        if (req_i) begin
          m_sp = sp_i; m_pc = ret_pc_i; m_ccr = ccr_i; m_ue = user_en_i; m_vec = vec_i;
          m_ph = sp_i[0] ? 6 : 1;
        end
      end else if (m_ph >= 1 && m_ph <= 4) begin
        if (mem_rdy_i) begin
          if (m_ph == 3) m_hi = mem_fn(BASE + AW'(4 * (8 + int'(m_vec))));
          if (m_ph == 4) begin
            e_pc  = {m_hi[7:0], mem_fn(BASE + AW'(4 * (8 + int'(m_vec))) + 24'd2)};
            e_sp  = m_sp - 24'd4;
            e_ccr = m_ue ? (m_ccr | 8'h80) : (m_ccr | 8'hC0);
            m_have = 1'b1;
          end
          m_ph++;
        end
      end else begin
        m_ph = 0;
      end
    end
  end

  task automatic trap(input logic [AW-1:0] sp, input logic [23:0] pc, input logic [7:0] ccr,
                      input logic ue, input logic [1:0] vec, input bit noisy);
    @(posedge clk); #1;
    req_i = 1'b1; sp_i = sp; ret_pc_i = pc; ccr_i = ccr; user_en_i = ue; vec_i = vec;
    @(posedge clk); #1;
    if (noisy) begin
      // R2: requests during busy must be ignored
      for (int k = 0; k < 2; k++) begin
        sp_i = 24'h00FFF0 + AW'(k); ret_pc_i = 24'hDEAD00; ccr_i = 8'h3C; vec_i = 2'(k);
        @(posedge clk); #1;
      end
    end
    req_i = 1'b0;
    while (busy_o) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    trap(24'h001000, 24'h123456, 8'h05, 1'b1, 2'd0, 1'b0);
    trap(24'h002002, 24'hABCDEF, 8'h21, 1'b0, 2'd1, 1'b0);
    trap(24'h000004, 24'h00FFFE, 8'hFF, 1'b0, 2'd2, 1'b1);
    trap(24'h000000, 24'hFEDCBA, 8'h00, 1'b1, 2'd3, 1'b0);
    // R11: odd stack pointer
    trap(24'h003001, 24'h111111, 8'h10, 1'b0, 2'd1, 1'b0);
    rdy_rand = 1'b1;
    for (int n = 0; n < 40; n++)
      trap({$urandom_range(0, 24'hFFFFFF)} & 24'hFFFFFE | AW'(n % 7 == 0),
           24'($urandom), 8'($urandom), 1'($urandom), 2'($urandom), (n % 3) == 0);
    rdy_rand = 1'b0;
    // back-to-back with request held high
    @(posedge clk); #1;
    req_i = 1'b1; sp_i = 24'h000800; ret_pc_i = 24'h000123; ccr_i = 8'h40;
    user_en_i = 1'b1; vec_i = 2'd2;
    repeat (14) @(posedge clk);
    #1 req_i = 1'b0;
    while (busy_o) begin
      @(posedge clk); #1;
    end
    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule